// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block is the architectural status/control word of a floating-point unit. It is a single 32-bit register made of three parts. The first is a four-bit condition code loaded by compare operations. The second is a set of mode controls that the arithmetic datapath reads: an alternative half-precision format select, a default-NaN select, a flush-to-zero select and a two-bit rounding mode. The third is six cumulative exception flags that the arithmetic unit sets with single-cycle pulses.

Software reads the register through a plain read bus and writes it through a one-cycle write strobe. A second register holds the values that the mode fields take when a new execution context begins. A context-start pulse copies them into the live mode fields. Five of the six flags are OR-ed into one registered interrupt request with no per-flag enable. The inexact flag can only be polled.

Top module: `fp_status_ctrl`

## Requirements
- R1: After a synchronous active-low reset with default parameters, `sw_rdata` reads 0, `dflt_rdata` reads 0, all mode outputs are 0 and `irq` is 0.
- R2: Only these bits exist: condition codes at 31 (negative), 30 (zero), 29 (carry) and 28 (overflow). Mode fields at 26 (alternative half), 25 (default NaN), 24 (flush-to-zero) and 23:22 (rounding). Flags at 7 (denormal flushed), 4 (inexact), 3 (underflow), 2 (overflow), 1 (divide by zero) and 0 (invalid). Every other bit reads 0 and ignores writes, so writing all ones reads back 0xF7C0009F.
- R3: When `cmp_done` is high, bits 31:28 load `cmp_nzcv` (bit 3 goes to bit 31). Without a compare or a software write, they keep their value whatever the flag and mode inputs do.
- R4: A one-cycle pulse on `exc_set` sets the matching flag, and the flag stays set in later cycles. The `exc_set` index maps to register bits as 0→0, 1→1, 2→2, 3→3, 4→4 (inexact) and 5→7 (denormal flushed).
- R5: A software write loads each flag with the written bit, so writing 0 clears it.
- R6: If a software write and an `exc_set` pulse for the same flag arrive in one cycle, the flag ends up set.
- R7: `irq` is registered. It rises one cycle after any of the underflow, overflow, divide-by-zero, invalid or denormal-flushed flags becomes set. It stays high while any of them is set, and falls one cycle after the last of them clears.
- R8: The inexact flag never raises `irq`.
- R9: A software write loads the mode fields. The outputs `mode_half_alt`, `mode_dnan`, `mode_flush` and `mode_rnd` follow the register bits. `mode_rnd` is encoded as 00 nearest-even, 01 toward +inf, 10 toward -inf and 11 toward zero.
- R10: The default register is written through `dflt_wr_en`/`dflt_wdata`. It keeps only bits 26:22 and reads back through `dflt_rdata` with all other bits 0. Writing it does not change the live mode fields.
- R11: A `ctx_start` pulse copies the default register's bits 26:22 into the live mode fields and leaves the flags and condition codes unchanged. If a software write arrives in the same cycle, `ctx_start` wins for the mode fields.
- R12: If `cmp_done` and a software write arrive in the same cycle, the condition codes take `cmp_nzcv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr_en | input | 1 | Software write strobe for the status word |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Current status word |
| dflt_wr_en | input | 1 | Write strobe for the default mode register |
| dflt_wdata | input | 32 | Default mode register write data |
| dflt_rdata | output | 32 | Default mode register contents |
| ctx_start | input | 1 | New context: load mode fields from defaults |
| cmp_done | input | 1 | Compare operation completed |
| cmp_nzcv | input | 4 | Compare result {N,Z,C,V} |
| exc_set | input | 6 | Per-cycle exception pulses from the arithmetic unit |
| mode_half_alt | output | 1 | Alternative half-precision format selected |
| mode_dnan | output | 1 | Default-NaN mode selected |
| mode_flush | output | 1 | Flush-to-zero mode selected |
| mode_rnd | output | 2 | Rounding mode |
| irq | output | 1 | Aggregated exception interrupt request |

## Verification
The hardest situation to reach is a collision, where two writers target the same field on the same clock edge. One case is a software clear meeting an exception pulse. Another is a software write meeting a compare completion or a context start. The directed tasks raise both strobes on one falling edge. They then read the word back to confirm that the hardware source won for the contested bits while the software value landed on the others. The interrupt is checked over two consecutive cycles, so that its one-cycle lag after a flag change is pinned down in both directions.

// File: rtl/fpsr_pkg.sv
// Package: shared constants, bit positions and types for the FP status word.
// Assumes a fixed 32-bit word layout that neighbouring logic decodes.
package fpsr_pkg;
    localparam int REG_W  = 32;
    localparam int CC_W   = 4;
    localparam int FLAG_N = 6;

    // Condition code and mode field positions in the word
    localparam int POS_CC_LO    = 28;
    localparam int POS_HALF_ALT = 26;
    localparam int POS_DNAN     = 25;
    localparam int POS_FLUSH    = 24;
    localparam int POS_RND_LO   = 22;

    // Flag indices inside the internal flag vector
    localparam int FI_INV = 0;
    localparam int FI_DVZ = 1;
    localparam int FI_OVF = 2;
    localparam int FI_UND = 3;
    localparam int FI_INX = 4;
    localparam int FI_DEN = 5;

    // Flags that feed the interrupt (all but inexact)
    localparam logic [FLAG_N-1:0] IRQ_SRC_MASK = ~(FLAG_N'(1) << FI_INX);

    typedef enum logic [1:0] {
        RND_NEAREST = 2'b00,
        RND_POS_INF = 2'b01,
        RND_NEG_INF = 2'b10,
        RND_ZERO    = 2'b11
    } rnd_mode_e;

    typedef struct packed {
        logic      half_alt;
        logic      dnan;
        logic      flush;
        rnd_mode_e rnd;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    // Word bit position of flag index i
    function automatic int flag_pos(input int i);
        return (i == FI_DEN) ? 7 : i;
    endfunction

    function automatic mode_t word_to_mode(input logic [REG_W-1:0] w);
        mode_t m;
        m.half_alt = w[POS_HALF_ALT];
        m.dnan     = w[POS_DNAN];
        m.flush    = w[POS_FLUSH];
        m.rnd      = rnd_mode_e'(w[POS_RND_LO +: 2]);
        return m;
    endfunction

    function automatic logic [REG_W-1:0] mode_to_word(input mode_t m);
        logic [REG_W-1:0] w;
        w = '0;
        w[POS_HALF_ALT]     = m.half_alt;
        w[POS_DNAN]         = m.dnan;
        w[POS_FLUSH]        = m.flush;
        w[POS_RND_LO +: 2]  = m.rnd;
        return w;
    endfunction
endpackage

// File: rtl/fpsr_cond.sv
// Condition code holder. Loads from a completed compare or a software
// write; the compare wins a same-cycle collision. Assumes cmp_done is a
// single-cycle strobe.
module fpsr_cond #(
    parameter int CC_W = fpsr_pkg::CC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_wr,
    input  logic [CC_W-1:0] sw_cc,
    input  logic            cmp_done,
    input  logic [CC_W-1:0] cmp_cc,
    output logic [CC_W-1:0] cc_q
);
    // Condition code register update with compare priority
    always_ff @(posedge clk) begin
        if (!rst_n)        cc_q <= '0;
        else if (cmp_done) cc_q <= cmp_cc;
        else if (sw_wr)    cc_q <= sw_cc;
    end

    // R3: codes hold when neither writer is active
    p_cc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_done && !sw_wr) |=> $stable(cc_q));

    // R12: compare result lands even under a software write
    p_cmp_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_done && sw_wr) |=> (cc_q == $past(cmp_cc)));
endmodule

// File: rtl/fpsr_mode.sv
// Live mode fields and the reset-default mode register. A context start
// copies the default register (value held before the edge) into the live
// fields and outranks a same-cycle software write.
module fpsr_mode #(
    parameter fpsr_pkg::mode_t RST_MODE = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_wr,
    input  fpsr_pkg::mode_t sw_mode,
    input  logic            dflt_wr,
    input  fpsr_pkg::mode_t dflt_wmode,
    input  logic            ctx_start,
    output fpsr_pkg::mode_t mode_q,
    output fpsr_pkg::mode_t dflt_q
);
    // Default register: software-written reset values for the modes
    always_ff @(posedge clk) begin
        if (!rst_n)       dflt_q <= RST_MODE;
        else if (dflt_wr) dflt_q <= dflt_wmode;
    end

    // Live mode register: context start beats software write
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= RST_MODE;
        else if (ctx_start) mode_q <= dflt_q;
        else if (sw_wr)     mode_q <= sw_mode;
    end

    // R11: context start installs the prior default contents
    p_ctx_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_start |=> (mode_q == $past(dflt_q)));

    // R9: modes change only through a write or a context start
    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctx_start && !sw_wr) |=> $stable(mode_q));

    // R10: writing the default register alone leaves live modes alone
    p_dflt_isolated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dflt_wr && !ctx_start && !sw_wr) |=> $stable(mode_q));
endmodule

// File: rtl/fpsr_flags.sv
// Sticky exception flags and the aggregated registered interrupt.
// Each flag takes the software value on a write, OR-ed with the
// hardware pulse so a same-cycle set wins. Assumes exc_set pulses are
// synchronous to clk.
module fpsr_flags #(
    parameter int                 FLAG_N   = fpsr_pkg::FLAG_N,
    parameter logic [FLAG_N-1:0]  IRQ_MASK = fpsr_pkg::IRQ_SRC_MASK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  logic [FLAG_N-1:0] sw_flags,
    input  logic [FLAG_N-1:0] exc_set,
    output logic [FLAG_N-1:0] flags_q,
    output logic              irq_q
);
    logic [FLAG_N-1:0] irq_src;

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        // One sticky flag bit with hardware-set priority
        always_ff @(posedge clk) begin
            if (!rst_n)          flags_q[i] <= 1'b0;
            else if (exc_set[i]) flags_q[i] <= 1'b1;
            else if (sw_wr)      flags_q[i] <= sw_flags[i];
        end
    end

    // Flags that are allowed to request an interrupt
    always_comb irq_src = flags_q & IRQ_MASK;

    // Registered interrupt request
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |irq_src;
    end

    // R4: without a software write no set flag ever drops
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R6: every pulsed flag is set afterwards, write or not
    p_hw_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|exc_set) |=> ((flags_q & $past(exc_set)) == $past(exc_set)));

    // R7: interrupt remains asserted while a source flag is still set
    p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && (|irq_src) && !sw_wr) |=> irq_q);

    // R7: a rising interrupt is preceded by a set source flag
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(|irq_src));

    // R8: with only inexact (or nothing) set, interrupt is low next cycle
    p_inexact_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_q & ~(FLAG_N'(1) << fpsr_pkg::FI_INX)) == '0) |=> !irq_q);
endmodule

// File: rtl/fp_status_ctrl.sv
// Top: floating-point status and control word. Splits the software
// write word into condition, mode and flag parts, and reassembles the
// read word with reserved bits at zero. DFLT_RST gives the reset value
// of both the default and live mode fields (only bits 26:22 are used).
module fp_status_ctrl #(
    parameter logic [31:0] DFLT_RST = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sw_wr_en,
    input  logic [31:0] sw_wdata,
    output logic [31:0] sw_rdata,
    input  logic        dflt_wr_en,
    input  logic [31:0] dflt_wdata,
    output logic [31:0] dflt_rdata,
    input  logic        ctx_start,
    input  logic        cmp_done,
    input  logic [3:0]  cmp_nzcv,
    input  logic [5:0]  exc_set,
    output logic        mode_half_alt,
    output logic        mode_dnan,
    output logic        mode_flush,
    output logic [1:0]  mode_rnd,
    output logic        irq
);
    import fpsr_pkg::*;

    localparam mode_t RST_MODE = word_to_mode(DFLT_RST);

    logic [CC_W-1:0]   cc_q;
    logic [FLAG_N-1:0] flags_q;
    logic [FLAG_N-1:0] sw_flags;
    mode_t             mode_q;
    mode_t             dflt_q;

    // Gather the flag bits out of the write word
    always_comb begin
        for (int i = 0; i < FLAG_N; i++) sw_flags[i] = sw_wdata[flag_pos(i)];
    end

    fpsr_cond #(.CC_W(CC_W)) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_wr    (sw_wr_en),
        .sw_cc    (sw_wdata[POS_CC_LO +: CC_W]),
        .cmp_done (cmp_done),
        .cmp_cc   (cmp_nzcv),
        .cc_q     (cc_q)
    );

    fpsr_mode #(.RST_MODE(RST_MODE)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_wr      (sw_wr_en),
        .sw_mode    (word_to_mode(sw_wdata)),
        .dflt_wr    (dflt_wr_en),
        .dflt_wmode (word_to_mode(dflt_wdata)),
        .ctx_start  (ctx_start),
        .mode_q     (mode_q),
        .dflt_q     (dflt_q)
    );

    fpsr_flags #(.FLAG_N(FLAG_N), .IRQ_MASK(IRQ_SRC_MASK)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_wr    (sw_wr_en),
        .sw_flags (sw_flags),
        .exc_set  (exc_set),
        .flags_q  (flags_q),
        .irq_q    (irq)
    );

    // Assemble the read word; unused positions stay zero
    always_comb begin
        sw_rdata = mode_to_word(mode_q);
        sw_rdata[POS_CC_LO +: CC_W] = cc_q;
        for (int i = 0; i < FLAG_N; i++) sw_rdata[flag_pos(i)] = flags_q[i];
    end

    // Default register read-back and mode outputs to the datapath
    always_comb begin
        dflt_rdata    = mode_to_word(dflt_q);
        mode_half_alt = mode_q.half_alt;
        mode_dnan     = mode_q.dnan;
        mode_flush    = mode_q.flush;
        mode_rnd      = mode_q.rnd;
    end

    // R11: context start leaves flags and condition codes untouched
    p_ctx_keeps_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_start && !sw_wr_en && !cmp_done && !(|exc_set))
        |=> (sw_rdata[31:28] == $past(sw_rdata[31:28]))
            && (sw_rdata[7:0] == $past(sw_rdata[7:0])));
endmodule

// File: tb/fp_status_ctrl_tb_top.sv
// Directed bench for fp_status_ctrl. Inputs change on falling edges,
// outputs are sampled on falling edges.
module fp_status_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sw_wr_en;
    logic [31:0] sw_wdata;
    logic [31:0] sw_rdata;
    logic        dflt_wr_en;
    logic [31:0] dflt_wdata;
    logic [31:0] dflt_rdata;
    logic        ctx_start;
    logic        cmp_done;
    logic [3:0]  cmp_nzcv;
    logic [5:0]  exc_set;
    logic        mode_half_alt;
    logic        mode_dnan;
    logic        mode_flush;
    logic [1:0]  mode_rnd;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;   // 4 ns period, 250 MHz

    fp_status_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .sw_wr_en(sw_wr_en), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .dflt_wr_en(dflt_wr_en), .dflt_wdata(dflt_wdata), .dflt_rdata(dflt_rdata),
        .ctx_start(ctx_start), .cmp_done(cmp_done), .cmp_nzcv(cmp_nzcv),
        .exc_set(exc_set),
        .mode_half_alt(mode_half_alt), .mode_dnan(mode_dnan),
        .mode_flush(mode_flush), .mode_rnd(mode_rnd), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic idle();
        sw_wr_en = 0; sw_wdata = '0; dflt_wr_en = 0; dflt_wdata = '0;
        ctx_start = 0; cmp_done = 0; cmp_nzcv = '0; exc_set = '0;
    endtask

    // Advance one clock: inputs set before this are taken at the rising edge
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic sw_write(input logic [31:0] d);
        sw_wr_en = 1; sw_wdata = d; step();
    endtask

    task automatic t_reset();
        check("R1 rdata", sw_rdata, 32'h0);
        check("R1 dflt", dflt_rdata, 32'h0);
        check("R1 modes", {27'h0, mode_half_alt, mode_dnan, mode_flush, mode_rnd}, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_reserved();
        sw_write(32'hFFFF_FFFF);
        check("R2 all-ones readback", sw_rdata, 32'hF7C0_009F);
        step();
        check("R7 irq after flags written", {31'h0, irq}, 32'h1);
        sw_write(32'h0);
        check("R5 cleared word", sw_rdata, 32'h0);
        step();
        check("R7 irq drops", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_cond();
        cmp_done = 1; cmp_nzcv = 4'b1010; step();
        check("R3 compare load", {28'h0, sw_rdata[31:28]}, 32'hA);
        exc_set = 6'b000100; ctx_start = 1; step();
        step();
        check("R3 codes held", {28'h0, sw_rdata[31:28]}, 32'hA);
        cmp_done = 1; cmp_nzcv = 4'b0011; sw_wr_en = 1; sw_wdata = 32'h5000_0000; step();
        check("R12 compare beats write", {28'h0, sw_rdata[31:28]}, 32'h3);
        sw_write(32'h0);
    endtask

    task automatic t_sticky();
        exc_set = 6'b000100; step();
        check("R4 overflow set", sw_rdata, 32'h0000_0004);
        check("R7 irq lags flag", {31'h0, irq}, 32'h0);
        step();
        check("R7 irq high", {31'h0, irq}, 32'h1);
        step(); step();
        exc_set = 6'b000010; step();
        check("R4 sticky accumulation", sw_rdata, 32'h0000_0006);
        check("R7 irq stays", {31'h0, irq}, 32'h1);
        exc_set = 6'b100000; step();
        check("R4 idx5 maps to bit7", sw_rdata, 32'h0000_0086);
        sw_write(32'h0000_0004);
        check("R5 partial clear", sw_rdata, 32'h0000_0004);
        step();
        check("R7 irq still set", {31'h0, irq}, 32'h1);
        sw_write(32'h0);
        step();
        check("R7 irq released", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_race();
        sw_write(32'h0000_0008);
        sw_wr_en = 1; sw_wdata = 32'h0000_0000; exc_set = 6'b000001; step();
        check("R6 hw set beats sw clear", sw_rdata, 32'h0000_0001);
        sw_write(32'h0);
        step();
    endtask

    task automatic t_inexact();
        exc_set = 6'b010000; step();
        check("R4 inexact set", sw_rdata, 32'h0000_0010);
        step(); step();
        check("R8 inexact no irq", {31'h0, irq}, 32'h0);
        exc_set = 6'b001000; step();
        step();
        check("R7 underflow irq", {31'h0, irq}, 32'h1);
        sw_write(32'h0000_0010);
        step();
        check("R8 inexact alone quiet", {31'h0, irq}, 32'h0);
        sw_write(32'h0);
    endtask

    task automatic t_mode();
        sw_write(32'h0180_0000);   // flush=1, rnd=10
        check("R9 word", sw_rdata, 32'h0180_0000);
        check("R9 rnd toward -inf", {30'h0, mode_rnd}, 32'h2);
        check("R9 flush", {31'h0, mode_flush}, 32'h1);
        sw_write(32'h06C0_0000);   // half_alt, dnan, rnd=11
        check("R9 modes", {27'h0, mode_half_alt, mode_dnan, mode_flush, mode_rnd}, 32'h1B);
    endtask

    task automatic t_default();
        dflt_wr_en = 1; dflt_wdata = 32'hFFFF_FFFF; step();
        check("R10 default masked", dflt_rdata, 32'h07C0_0000);
        check("R10 live modes unchanged", sw_rdata, 32'h06C0_0000);
        dflt_wr_en = 1; dflt_wdata = 32'h0140_0000; step();   // flush, rnd=01
        cmp_done = 1; cmp_nzcv = 4'b0110; step();
        exc_set = 6'b000010; step();
        ctx_start = 1; step();
        check("R11 context load keeps status", sw_rdata, 32'h6140_0002);
        check("R11 rnd toward +inf", {30'h0, mode_rnd}, 32'h1);
        dflt_wr_en = 1; dflt_wdata = 32'h0000_0000; step();
        ctx_start = 1; sw_wr_en = 1; sw_wdata = 32'h07C0_0000; step();
        check("R11 context beats write", sw_rdata, 32'h0);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_reserved();
        t_cond();
        t_sticky();
        t_race();
        t_inexact();
        t_mode();
        t_default();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule